// File: doc/BRIEF.md
# Dual Performance Event Counter Unit

This block is a small performance monitoring unit with two 32-bit event counters and one control register. The control register is shared by both counters. Each counter adds one for every cycle in which its chosen event strobe is high, but only while the processor's current privilege context is enabled. A single set of context enables covers both counters, so one counter cannot be stopped while the other keeps running. Each counter does have its own event-select field.

Both counters are reached through one 64-bit counter register that can be written a half at a time. Software can preload a counter with the two's complement of a period. The counter then wraps after exactly that many events. A wrap sets a sticky overflow flag, and the flags drive an interrupt output when interrupts are enabled.

Top module: `pmu_dual_ctr`

## Requirements
- R1: After reset both counters read zero, every enable bit and both overflow flags are clear, both select fields hold 0xFF (a code that never fires), the control register reads 64'h0000_0000_FF00_FF00, and irq_o is low.
- R2: With reg_sel=1 the counter register is addressed: counter 0 sits in bits 63:32 and counter 1 in bits 31:0. A write loads bits 63:32 only when reg_be[1] is set and bits 31:0 only when reg_be[0] is set; a half whose enable is clear keeps its value.
- R3: The privilege input is encoded 0=user, 1=supervisor, 2=hypervisor and 3=no context. A counter can step only when the enable for the current privilege is set in the control register: bit 0 for user, bit 1 for supervisor, bit 2 for hypervisor. Privilege 3 never counts.
- R4: When control bits 2:0 are all clear, neither counter changes under any privilege or event input, apart from register writes.
- R5: When a counter steps from 0xFFFFFFFF it becomes 0 and sets its overflow flag: control bit 5 for counter 0, control bit 4 for counter 1.
- R6: Counter 0 takes its event code from control bits 31:24 and counter 1 from bits 15:8. Code 0 counts every cycle. Code c, for c from 1 to 4, counts cycles with evt_i[c-1] high; evt_i[0] is the completed-instruction strobe. Any other code never counts.
- R7: In a cycle where a counter half is written, that counter takes the written value and does not also step.
- R8: Writing a control word with bit 5 or bit 4 set clears the matching overflow flag. Writing 0 to those bits leaves the flags alone. A wrap in the same cycle as a clear leaves the flag set.
- R9: irq_o is high exactly when control bit 3 (interrupt enable) is set and at least one overflow flag is set.
- R10: A counter preloaded with 2^32 - N overflows on exactly the N-th counted event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 4 | Event strobes; bit 0 is completed instructions |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 2 hypervisor, 3 none |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the counter register |
| reg_be | input | 2 | Half enables for counter writes (bit 1 upper, bit 0 lower) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| irq_o | output | 1 | Overflow interrupt |

## Verification
All state in this block can be read back, so a wrong counter value, select field or enable bit shows up on reg_rdata on the first read after the cycle in which it went wrong. A missed or duplicated step shows up as an off-by-one count. A wrong wrap detection shows up at once as a missing or spurious bit 5 or bit 4, and as a wrong irq_o level in the same cycle. The checks therefore freeze counting with privilege 3 before each read, which makes every expected value an exact number of events.

// File: rtl/pmu_defs_pkg.sv
package pmu_defs_pkg;
    typedef enum logic [1:0] {
        PRIV_USER = 2'd0,
        PRIV_SUP  = 2'd1,
        PRIV_HYP  = 2'd2,
        PRIV_NONE = 2'd3
    } priv_e;

    // Lane indices: lane 0 is the upper half of the counter register.
    localparam int LANE_HI = 0;
    localparam int LANE_LO = 1;
    localparam int LANES   = 2;
endpackage

// File: rtl/pmu_ctx_gate.sv
module pmu_ctx_gate
    import pmu_defs_pkg::*;
(
    input  logic [1:0] priv_i,
    input  logic       en_user,
    input  logic       en_sup,
    input  logic       en_hyp,
    output logic       ctx_ok
);
    always_comb begin
        case (priv_e'(priv_i))
            PRIV_USER: ctx_ok = en_user;
            PRIV_SUP:  ctx_ok = en_sup;
            PRIV_HYP:  ctx_ok = en_hyp;
            default:   ctx_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmu_evt_pick.sv
module pmu_evt_pick #(
    parameter int SEL_W   = 8,
    parameter int NUM_EVT = 4
) (
    input  logic [SEL_W-1:0]   code,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               hit
);
    always_comb begin
        hit = (code == '0);
        for (int k = 0; k < NUM_EVT; k++) begin
            if (code == SEL_W'(k + 1)) hit = evt_i[k];
        end
    end
endmodule

// File: rtl/pmu_cnt_lane.sv
module pmu_cnt_lane #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             step,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt_d,
    output logic             wrap
);
    always_comb begin
        wrap  = 1'b0;
        cnt_d = cnt_q;
        if (wr_en) begin
            cnt_d = wr_val;
        end else if (step) begin
            cnt_d = cnt_q + CNT_W'(1);
            wrap  = &cnt_q;
        end
    end
endmodule

// File: rtl/pmu_dual_ctr.sv
module pmu_dual_ctr
    import pmu_defs_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int SEL_W    = 8,
    parameter int NUM_EVT  = 4,
    parameter int HI_SHIFT = 24,
    parameter int LO_SHIFT = 8,
    parameter int OVF_BASE = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EVT-1:0]   evt_i,
    input  logic [1:0]           priv_i,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [1:0]           reg_be,
    input  logic [2*CNT_W-1:0]   reg_wdata,
    output logic [2*CNT_W-1:0]   reg_rdata,
    output logic                 irq_o
);
    localparam int REG_W   = 2 * CNT_W;
    localparam int BIT_USR = 0;
    localparam int BIT_SUP = 1;
    localparam int BIT_HYP = 2;
    localparam int BIT_IRQ = 3;
    localparam logic [SEL_W-1:0] SEL_IDLE = '1;

    typedef struct packed {
        logic [LANES-1:0][CNT_W-1:0] cnt;
        logic [LANES-1:0][SEL_W-1:0] sel;
        logic [LANES-1:0]            ovf;
        logic                        en_u;
        logic                        en_s;
        logic                        en_h;
        logic                        irq_en;
    } st_t;

    st_t st_q, st_d;

    logic                        ctx_ok;
    logic                        ctrl_wr;
    logic [LANES-1:0]            cnt_wr;
    logic [LANES-1:0][CNT_W-1:0] wr_val;
    logic [LANES-1:0]            hit;
    logic [LANES-1:0]            wrap;
    logic [LANES-1:0][CNT_W-1:0] cnt_nxt;
    logic [LANES-1:0]            clr_req;
    logic [REG_W-1:0]            ctrl_img;

    // Lane-to-field placement: upper lane uses HI_SHIFT / data bits above CNT_W
    function automatic int sel_pos(input int lane);
        return (lane == LANE_HI) ? HI_SHIFT : LO_SHIFT;
    endfunction

    function automatic int ovf_pos(input int lane);
        return OVF_BASE + (LANES - 1 - lane);
    endfunction

    assign ctrl_wr = reg_wr & ~reg_sel;

    pmu_ctx_gate u_gate (
        .priv_i  (priv_i),
        .en_user (st_q.en_u),
        .en_sup  (st_q.en_s),
        .en_hyp  (st_q.en_h),
        .ctx_ok  (ctx_ok)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HALF = (g == LANE_HI) ? 1 : 0;

        assign cnt_wr[g]  = reg_wr & reg_sel & reg_be[HALF];
        assign wr_val[g]  = reg_wdata[HALF*CNT_W +: CNT_W];
        assign clr_req[g] = ctrl_wr & reg_wdata[ovf_pos(g)];

        pmu_evt_pick #(
            .SEL_W   (SEL_W),
            .NUM_EVT (NUM_EVT)
        ) u_pick (
            .code  (st_q.sel[g]),
            .evt_i (evt_i),
            .hit   (hit[g])
        );

        pmu_cnt_lane #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .cnt_q  (st_q.cnt[g]),
            .step   (hit[g] & ctx_ok),
            .wr_en  (cnt_wr[g]),
            .wr_val (wr_val[g]),
            .cnt_d  (cnt_nxt[g]),
            .wrap   (wrap[g])
        );
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < LANES; i++) begin
            st_d.cnt[i] = cnt_nxt[i];
            // a wrap in the same cycle wins over a clear
            st_d.ovf[i] = wrap[i] | (st_q.ovf[i] & ~clr_req[i]);
            if (ctrl_wr) st_d.sel[i] = reg_wdata[sel_pos(i) +: SEL_W];
        end
        if (ctrl_wr) begin
            st_d.en_u   = reg_wdata[BIT_USR];
            st_d.en_s   = reg_wdata[BIT_SUP];
            st_d.en_h   = reg_wdata[BIT_HYP];
            st_d.irq_en = reg_wdata[BIT_IRQ];
        end
        if (!rst_n) begin
            st_d        = '0;
            st_d.sel[0] = SEL_IDLE;
            st_d.sel[1] = SEL_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Read image of the control register
    always_comb begin
        ctrl_img          = '0;
        ctrl_img[BIT_USR] = st_q.en_u;
        ctrl_img[BIT_SUP] = st_q.en_s;
        ctrl_img[BIT_HYP] = st_q.en_h;
        ctrl_img[BIT_IRQ] = st_q.irq_en;
        for (int i = 0; i < LANES; i++) begin
            ctrl_img[ovf_pos(i)]          = st_q.ovf[i];
            ctrl_img[sel_pos(i) +: SEL_W] = st_q.sel[i];
        end
    end

    assign reg_rdata = reg_sel ? {st_q.cnt[LANE_HI], st_q.cnt[LANE_LO]} : ctrl_img;
    assign irq_o     = st_q.irq_en & (|st_q.ovf);

    // Plain views of the state for the bound checker
    logic [CNT_W-1:0] mon_cnt_hi, mon_cnt_lo;
    logic             mon_ovf_hi, mon_ovf_lo, mon_irq_en, mon_any_en;
    assign mon_cnt_hi = st_q.cnt[LANE_HI];
    assign mon_cnt_lo = st_q.cnt[LANE_LO];
    assign mon_ovf_hi = st_q.ovf[LANE_HI];
    assign mon_ovf_lo = st_q.ovf[LANE_LO];
    assign mon_irq_en = st_q.irq_en;
    assign mon_any_en = st_q.en_u | st_q.en_s | st_q.en_h;
endmodule

// File: rtl/pmu_dual_ctr_chk.sv
module pmu_dual_ctr_chk #(
    parameter int CNT_W    = 32,
    parameter int OVF_BASE = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         priv_i,
    input logic               reg_wr,
    input logic               reg_sel,
    input logic [1:0]         reg_be,
    input logic [2*CNT_W-1:0] reg_wdata,
    input logic               irq_o,
    input logic [CNT_W-1:0]   cnt_hi,
    input logic [CNT_W-1:0]   cnt_lo,
    input logic               ovf_hi,
    input logic               ovf_lo,
    input logic               irq_en,
    input logic               any_en
);
    logic cnt_w;
    assign cnt_w = reg_wr & reg_sel;

    a_r3_no_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == 2'd3 && !cnt_w) |=> ($stable(cnt_hi) && $stable(cnt_lo)));

    a_r4_all_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_en && !cnt_w) |=> ($stable(cnt_hi) && $stable(cnt_lo)));

    a_r5_wrap_flags_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_w && cnt_hi == '1) |=> (cnt_hi == '1 || (cnt_hi == '0 && ovf_hi)));

    a_r5_wrap_flags_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_w && cnt_lo == '1) |=> (cnt_lo == '1 || (cnt_lo == '0 && ovf_lo)));

    a_r7_write_wins_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_w && reg_be[1]) |=> (cnt_hi == $past(reg_wdata[2*CNT_W-1:CNT_W])));

    a_r2_half_kept_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_w && !reg_be[0] && priv_i == 2'd3) |=> $stable(cnt_lo));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_hi && !(reg_wr && !reg_sel && reg_wdata[OVF_BASE+1])) |=> ovf_hi);

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o);
endmodule

bind pmu_dual_ctr pmu_dual_ctr_chk #(
    .CNT_W    (CNT_W),
    .OVF_BASE (OVF_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .priv_i    (priv_i),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .irq_o     (irq_o),
    .cnt_hi    (mon_cnt_hi),
    .cnt_lo    (mon_cnt_lo),
    .ovf_hi    (mon_ovf_hi),
    .ovf_lo    (mon_ovf_lo),
    .irq_en    (mon_irq_en),
    .any_en    (mon_any_en)
);

// File: tb/pmu_dual_ctr_test.sv
`timescale 1ns/1ps
module pmu_dual_ctr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt_i = '0;
    logic [1:0]  priv_i = 2'd3;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [1:0]  reg_be = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [63:0] data;
        logic        irq;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;   // 50 MHz

    pmu_dual_ctr uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .priv_i    (priv_i),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    // Monitor: compares queued expectations mid-way through the low phase
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (reg_rdata !== e.data || irq_o !== e.irq) begin
                    n_bad++;
                    $display("FAIL %s: data=%h irq=%b expected data=%h irq=%b",
                             e.tag, reg_rdata, irq_o, e.data, e.irq);
                end
            end
        end
    end

    task automatic expect_rd(input logic sel, input logic [63:0] d,
                             input logic irq, input string tag);
        exp_t e;
        reg_sel = sel;
        e.data = d; e.irq = irq; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [1:0] be, input logic [63:0] d);
        reg_sel = sel; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic run(input logic [1:0] p, input logic [3:0] e, input int n);
        priv_i = p; evt_i = e;
        repeat (n) @(negedge clk);
        priv_i = 2'd3; evt_i = '0;
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_rd(0, 64'h0000_0000_FF00_FF00, 0, "R1 ctrl reset image");
        expect_rd(1, 64'h0, 0, "R1 counters reset");
        run(2'd0, 4'hF, 4);
        expect_rd(1, 64'h0, 0, "R1 idle codes and clear enables do not count");

        // R2 half writes
        wr(1, 2'b11, {32'h1111_2222, 32'h3333_4444});
        expect_rd(1, {32'h1111_2222, 32'h3333_4444}, 0, "R2 full write");
        wr(1, 2'b10, {32'hAAAA_5555, 32'hDEAD_BEEF});
        expect_rd(1, {32'hAAAA_5555, 32'h3333_4444}, 0, "R2 upper-only write");
        wr(1, 2'b01, {32'h0, 32'h0000_0010});
        expect_rd(1, {32'hAAAA_5555, 32'h0000_0010}, 0, "R2 lower-only write");
        wr(1, 2'b11, 64'h0);

        // R3 context gating, both counters on cycle code
        wr(0, 2'b00, 64'h1);
        run(2'd1, 4'h0, 5);
        run(2'd2, 4'h0, 2);
        expect_rd(1, 64'h0, 0, "R3 user-only enable ignores sup/hyp");
        run(2'd0, 4'h0, 4);
        expect_rd(1, {32'd4, 32'd4}, 0, "R3 user context counts both");
        expect_rd(0, 64'h1, 0, "R3 ctrl readback");
        wr(0, 2'b00, 64'h2);
        run(2'd0, 4'h0, 3);
        run(2'd1, 4'h0, 3);
        expect_rd(1, {32'd7, 32'd7}, 0, "R3 supervisor-only enable");
        wr(0, 2'b00, 64'h7);
        run(2'd3, 4'h0, 5);
        expect_rd(1, {32'd7, 32'd7}, 0, "R3 privilege 3 never counts");

        // R4 all enables clear
        wr(0, 2'b00, 64'h0);
        run(2'd0, 4'hF, 3);
        run(2'd1, 4'hF, 3);
        run(2'd2, 4'hF, 3);
        expect_rd(1, {32'd7, 32'd7}, 0, "R4 all enables clear stops both");

        // R6 event select
        wr(1, 2'b11, 64'h0);
        wr(0, 2'b00, 64'h0100_0204);
        run(2'd2, 4'b0001, 3);
        run(2'd2, 4'b0010, 2);
        run(2'd2, 4'b0011, 1);
        run(2'd2, 4'b1000, 2);
        expect_rd(1, {32'd4, 32'd3}, 0, "R6 codes 1 and 2 pick evt bits");
        wr(0, 2'b00, 64'h0400_FF04);
        run(2'd2, 4'b1111, 5);
        expect_rd(1, {32'd9, 32'd3}, 0, "R6 code 4 counts, code FF never");

        // R10 / R5 / R9 preload and overflow of counter 0
        wr(1, 2'b11, {32'hFFFF_FFFE, 32'd5});
        wr(0, 2'b00, 64'h1);
        run(2'd0, 4'h0, 1);
        expect_rd(1, {32'hFFFF_FFFF, 32'd6}, 0, "R10 no overflow before Nth event");
        expect_rd(0, 64'h1, 0, "R10 flag still clear");
        run(2'd0, 4'h0, 1);
        expect_rd(1, {32'h0, 32'd7}, 0, "R5 counter 0 wraps to zero");
        expect_rd(0, 64'h21, 0, "R5 bit 5 set, R9 irq low while disabled");
        wr(0, 2'b00, 64'h9);
        expect_rd(0, 64'h29, 1, "R9 irq high once enabled; R8 writing 0 keeps flag");
        wr(0, 2'b00, 64'h28);
        expect_rd(0, 64'h08, 0, "R8 write 1 clears bit 5");

        // R5 counter 1 wrap
        wr(1, 2'b11, {32'h0, 32'hFFFF_FFFF});
        wr(0, 2'b00, 64'h9);
        run(2'd0, 4'h0, 1);
        expect_rd(1, {32'd1, 32'h0}, 1, "R5 counter 1 wraps");
        expect_rd(0, 64'h19, 1, "R5 bit 4 set for counter 1");
        wr(0, 2'b00, 64'h18);
        expect_rd(0, 64'h08, 0, "R8 write 1 clears bit 4");

        // R7 write beats increment
        wr(0, 2'b00, 64'h1);
        priv_i = 2'd0;
        wr(1, 2'b11, {32'd100, 32'd200});
        priv_i = 2'd3;
        expect_rd(1, {32'd100, 32'd200}, 0, "R7 write wins over step");
        priv_i = 2'd0;
        wr(1, 2'b10, {32'd500, 32'd0});
        priv_i = 2'd3;
        expect_rd(1, {32'd500, 32'd201}, 0, "R7 unwritten half still steps");

        // R8 wrap in the same cycle as a clear keeps the flag
        wr(1, 2'b11, {32'hFFFF_FFFF, 32'h0});
        priv_i = 2'd0;
        wr(0, 2'b00, 64'h21);
        priv_i = 2'd3;
        expect_rd(1, {32'h0, 32'd1}, 0, "R8 counters after wrap");
        expect_rd(0, 64'h21, 0, "R8 set wins over clear");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule